// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Controller with Set/Clear Fields

This block controls a small group of general-purpose pins from a configuration register port. Each pin's direction and output level are kept in two internal state vectors: a drive-enable vector and an output-level vector. Software never writes these vectors directly. Each vector has one field that only raises bits and another that only lowers bits, so a write touches exactly the pins whose data bits are 1. Pins that the write does not select keep their state, so no read-modify-write is needed.

The bus decoder in front of the block turns each field access into a one-cycle strobe that comes with 4-bit write data. It also presents a field selector for reads. A read of the raise or lower field returns the current value of the vector behind it. A read of the input field returns the pin levels after a two-flop synchronizer, whatever the direction of each pin. The block drives a level and a tri-state enable for each pin toward the pad ring.

Top module: `gpio_setclr`

## Requirements
- R1: While and after reset, every pin has its drive enable at 0, every stored output level is 0, and `pin_out` is 0.
- R2: A strobe on `wr_strb[0]` (enable-raise field) sets the drive enable of every pin whose `wr_data` bit is 1, from the next clock edge.
- R3: A strobe on `wr_strb[1]` (enable-lower field) clears the drive enable of every pin whose `wr_data` bit is 1, so the pin becomes input only from the next clock edge.
- R4: A strobe on `wr_strb[2]` (level-raise field) sets the stored output level, and a strobe on `wr_strb[3]` (level-lower field) clears it, for every pin whose `wr_data` bit is 1, from the next clock edge.
- R5: A bit of `wr_data` that is 0 leaves that pin's enable and level unchanged, whichever raise or lower strobe is active.
- R6: When the raise and lower strobes of the same vector are both active in one cycle, a pin whose data bit is 1 ends up cleared.
- R7: `pin_oe` shows the drive enable. `pin_out` carries the stored level of a pin only while that pin's enable is 1, and is 0 otherwise.
- R8: A read with `rd_sel` = 4 returns the pin inputs delayed by exactly two clock edges through the synchronizer. This holds for input-only pins and for driven pins alike.
- R9: A read with `rd_sel` = 0 or 1 returns the drive-enable vector. A read with 2 or 3 returns the stored level vector. A read with 5, 6 or 7 returns 0. Read data is combinational from `rd_sel`.
- R10: A strobe on `wr_strb[4]` (the read-only input field) changes neither vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_strb | input | 5 | One-cycle write strobes: [0] enable raise, [1] enable lower, [2] level raise, [3] level lower, [4] input field |
| wr_data | input | NPINS | Write data, one bit per pin |
| rd_sel | input | 3 | Read field selector |
| rd_data | output | NPINS | Read data for the selected field |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output level toward the pads |
| pin_oe | output | NPINS | Tri-state driver enable per pin |

## Verification
The raise and lower strobes of one vector can be active in the same cycle and can select overlapping bits. The random phase draws each strobe on its own, so all four strobes appear together in many cycles. Directed cycles also set both strobes of a vector with all data bits at 1. The bench model applies raise first and lower second, so the expected value of a pin selected by both is 0. After every edge, the enables and levels at the ports and through the read port are compared against that model.

// File: rtl/gpio_setclr.sv
module gpio_setclr #(
  parameter int NPINS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       wr_strb,
  input  logic [NPINS-1:0] wr_data,
  input  logic [2:0]       rd_sel,
  output logic [NPINS-1:0] rd_data,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NPINS-1:0] oe_q;
  logic [NPINS-1:0] lvl_q;
  logic [NPINS-1:0] sync_q [SYNC_STAGES];

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oe_q[i]  <= 1'b0;
        lvl_q[i] <= 1'b0;
      end else begin
        if (wr_strb[1] && wr_data[i])      oe_q[i] <= 1'b0;
        else if (wr_strb[0] && wr_data[i]) oe_q[i] <= 1'b1;
        if (wr_strb[3] && wr_data[i])      lvl_q[i] <= 1'b0;
        else if (wr_strb[2] && wr_data[i]) lvl_q[i] <= 1'b1;
      end
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= pin_in;
      else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  assign pin_oe  = oe_q;
  assign pin_out = oe_q & lvl_q;

  always_comb begin
    case (rd_sel)
      3'd0, 3'd1: rd_data = oe_q;
      3'd2, 3'd3: rd_data = lvl_q;
      3'd4:       rd_data = sync_q[LAST];
      default:    rd_data = '0;
    endcase
  end

endmodule

module gpio_setclr_chk #(
  parameter int NPINS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [4:0]       wr_strb,
  input logic [NPINS-1:0] wr_data,
  input logic [2:0]       rd_sel,
  input logic [NPINS-1:0] rd_data,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0));

  assert_oe_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strb[0] && !wr_strb[1]) |=> ((pin_oe & $past(wr_data)) == $past(wr_data)));

  assert_oe_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strb[1] |=> ((pin_oe & $past(wr_data)) == '0));

  assert_zero_bits_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_oe & ~$past(wr_data)) == ($past(pin_oe) & ~$past(wr_data))));

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strb[0] && wr_strb[1]) |=> ((pin_oe & $past(wr_data)) == '0));

  assert_drive_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  assert_oe_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 3'd0 || rd_sel == 3'd1) |-> (rd_data == pin_oe));

  assert_input_write_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strb[3:0] == 4'b0) |=> $stable(pin_oe));

endmodule

bind gpio_setclr gpio_setclr_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_strb(wr_strb), .wr_data(wr_data),
  .rd_sel(rd_sel), .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/test_gpio_setclr.sv
module test_gpio_setclr;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [4:0]   wr_strb = '0;
  logic [N-1:0] wr_data = '0;
  logic [2:0]   rd_sel = '0;
  logic [N-1:0] rd_data, pin_in = '0, pin_out, pin_oe;

  int checks = 0;
  int errors = 0;

  logic [N-1:0] m_oe = '0, m_lvl = '0, m_s1 = '0, m_s2 = '0;

  gpio_setclr #(.NPINS(N)) i_gpio_setclr (
    .clk(clk), .rst_n(rst_n), .wr_strb(wr_strb), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] upd(logic [N-1:0] cur, logic raise, logic lower,
                                       logic [N-1:0] d);
    logic [N-1:0] v = cur;
    if (raise) v = v | d;
    if (lower) v = v & ~d;
    return v;
  endfunction

  function automatic logic [N-1:0] exp_rd(logic [2:0] sel);
    case (sel)
      3'd0, 3'd1: return m_oe;
      3'd2, 3'd3: return m_lvl;
      3'd4:       return m_s2;
      default:    return '0;
    endcase
  endfunction

  task automatic compare(string tag);
    chk({tag, " R7 pin_oe"}, pin_oe, m_oe);
    chk({tag, " R7 pin_out"}, pin_out, m_oe & m_lvl);
    chk({tag, " R9 rd_data"}, rd_data, exp_rd(rd_sel));
  endtask

  task automatic step(string tag, logic [4:0] s, logic [N-1:0] d,
                      logic [N-1:0] p, logic [2:0] sel);
    wr_strb = s; wr_data = d; pin_in = p; rd_sel = sel;
    @(posedge clk);
    m_oe  = upd(m_oe,  s[0], s[1], d);
    m_lvl = upd(m_lvl, s[2], s[3], d);
    m_s2  = m_s1;
    m_s1  = p;
    @(negedge clk);
    wr_strb = '0;
    compare(tag);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    pin_in = 4'hF;
    repeat (3) @(negedge clk);
    chk("R1 reset pin_oe", pin_oe, '0);
    chk("R1 reset pin_out", pin_out, '0);
    rd_sel = 3'd2; #0.1;
    chk("R1 reset level", rd_data, '0);
    rd_sel = 3'd4; #0.1;
    chk("R1 reset sync", rd_data, '0);
    pin_in = '0;
    rst_n = 1'b1;
    @(negedge clk);

    step("R4 raise level while undriven", 5'b00100, 4'hF, 4'h0, 3'd2);
    chk("R7 undriven pin_out", pin_out, '0);
    step("R2 raise enable", 5'b00001, 4'h5, 4'h0, 3'd0);
    chk("R2 enable bits", pin_oe, 4'h5);
    step("R3 lower enable", 5'b00010, 4'h1, 4'h0, 3'd1);
    chk("R3 enable bits", pin_oe, 4'h4);
    step("R4 lower level", 5'b01000, 4'h4, 4'h0, 3'd3);
    chk("R4 level driven low", pin_out, 4'h0);
    step("R5 zero data", 5'b01111, 4'h0, 4'h0, 3'd2);
    step("R6 enable conflict", 5'b00011, 4'hF, 4'h0, 3'd0);
    chk("R6 enable cleared", pin_oe, 4'h0);
    step("R2 restore", 5'b00101, 4'hF, 4'h0, 3'd0);
    step("R6 level conflict", 5'b01100, 4'h6, 4'h0, 3'd3);
    chk("R6 level cleared", pin_out, 4'h9);
    step("R10 input field write", 5'b10000, 4'h0, 4'h0, 3'd4);
    chk("R10 enable kept", pin_oe, 4'hF);
    step("R10 input field write ones", 5'b10000, 4'hF, 4'hA, 3'd2);
    chk("R10 level kept", rd_data, 4'h9);
    step("R8 first edge", 5'b00000, 4'h0, 4'hA, 3'd4);
    chk("R8 after two edges", rd_data, 4'hA);
    step("R8 change", 5'b00000, 4'h0, 4'h3, 3'd4);
    chk("R8 one edge old value", rd_data, 4'hA);
    step("R8 hold", 5'b00000, 4'h0, 4'h3, 3'd4);
    chk("R8 two edges new value", rd_data, 4'h3);
    step("R9 unused select", 5'b00000, 4'h0, 4'h3, 3'd6);

    for (int k = 0; k < 600; k++) begin
      logic [4:0] s;
      s[0] = ($urandom % 3) == 0;
      s[1] = ($urandom % 3) == 0;
      s[2] = ($urandom % 3) == 0;
      s[3] = ($urandom % 3) == 0;
      s[4] = ($urandom % 5) == 0;
      step("random", s, N'($urandom), N'($urandom), 3'($urandom));
    end

    rst_n = 1'b0;
    m_oe = '0; m_lvl = '0; m_s1 = '0; m_s2 = '0;
    #1;
    chk("R1 async reset pin_oe", pin_oe, '0);
    chk("R1 async reset pin_out", pin_out, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule